// File: doc/BRIEF.md
# Link Training State History Recorder

This block watches the link-training state machine of a serial link controller and keeps a circular record of every change of its state. On each clock it samples a 6-bit training state, a 3-bit rate code and a 3-bit low-power substate code. When capture is on and the state differs from the last one stored, the block writes one entry into a 64-deep ring. A small register port lets software turn capture on and off, hold four plain match-qualifier words, and pop history entries one read at a time through a status word.

The ring keeps two pointers. The write pointer tracks the slot hardware fills next. The read pointer tracks the software's position. A status read that finds an unread entry returns it and advances the read pointer. A status read that finds nothing new returns the previously returned word again and moves nothing. Software therefore treats two identical consecutive states as the end of valid data, and a later poll carries on from where it stopped. When the ring is full, a new entry replaces the oldest unread one and the read pointer moves forward with it.

Top module: `lts_history`

## Requirements
- R1: After reset the ring is empty, the control and match words read as 0, and a status read returns 0x00000000.
- R2: Writes to the control word (offset 0x310) and the four match words (offsets 0x320, 0x324, 0x328, 0x32C) use bits 31:16 as a per-bit write enable for bits 15:0. Reads of these offsets return the stored 16 bits in bits 15:0 and zero above. Any other offset reads as 0.
- R3: Capture is on while bit 0 of the control word is 1 (writing 0xFFFF0007 turns it on and 0xFFFF0000 turns it off). While capture is off, state changes store nothing.
- R4: An entry is stored only when the 6-bit state differs from the last stored state. The first sample after reset with capture on is always stored. Changes of rate or substate alone store nothing.
- R5: The status word at offset 0x350 carries the state in bits 5:0, the substate code in bits 10:8 and the rate code in bits 22:20, with all other bits zero.
- R6: Status reads return stored entries oldest first, and each read that returns an unread entry advances the read pointer by one.
- R7: A status read with no unread entry returns the previously returned status word and leaves both pointers unchanged. Entries stored later are returned by subsequent reads, continuing from the saved position.
- R8: The ring holds 64 entries. Storing into a full ring overwrites the oldest unread entry and advances the read pointer, so the 64 newest entries remain readable in order. A read and a store in the same cycle on a full ring return the oldest entry and keep the ring full.
- R9: While capture is off, both pointers are frozen: status reads return the previously returned word and consume nothing. Unread entries stay readable after capture is turned on again.
- R10: Every register read returns its data exactly one cycle later, with bus_rvalid_o high for that single cycle. bus_rvalid_o is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_state_i | input | 6 | Current link training state |
| lnk_rate_i | input | 3 | Current link rate code |
| lnk_sub_i | input | 3 | Low-power substate code (1 for the shallow and 2 for the deep idle substate) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data: mask in bits 31:16, value in bits 15:0 |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
The state input is driven with runs that hold a value over several cycles while rate and substate change underneath, which separates change detection on the state alone from detection on the whole sample. A drain phase reads past the newest entry and then feeds new states, which shows that the repeat-last-word rule and resumption from the saved read position both hold. A 70-entry burst followed by a full drain, and a read paired with a store on a full ring, show the overwrite and read-pointer advance. Toggling capture off with reads and state changes in between shows that the frozen pointers consume nothing and store nothing.

// File: rtl/lts_hist_pkg.sv
package lts_hist_pkg;

  localparam int ST_W   = 6;
  localparam int RATE_W = 3;
  localparam int SUB_W  = 3;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [SUB_W-1:0]  sub;
    logic [ST_W-1:0]   state;
  } hist_entry_t;

  localparam int ENTRY_W = $bits(hist_entry_t);

  // Merge a 16-bit value under the upper-half write enable.
  function automatic logic [15:0] wmask_merge(input logic [15:0] cur,
                                               input logic [31:0] wd);
    return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

  // Place an entry's fields at their status-word positions.
  function automatic logic [31:0] status_word(input hist_entry_t e);
    logic [31:0] w;
    w        = '0;
    w[5:0]   = e.state;
    w[10:8]  = e.sub;
    w[22:20] = e.rate;
    return w;
  endfunction

  // Ring index advance with wrap at an arbitrary depth.
  function automatic int unsigned wrap_inc(input int unsigned p,
                                           input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/lts_hist_capture.sv
module lts_hist_capture
  import lts_hist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ST_W-1:0]   state_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic              push,
  output hist_entry_t       entry
);

  logic [ST_W-1:0] last_q;
  logic            have_q;

  assign push  = en && (!have_q || (state_i != last_q));
  assign entry = '{rate: rate_i, sub: sub_i, state: state_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (push) begin
      last_q <= state_i;
      have_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lts_hist_ring.sv
module lts_hist_ring
  import lts_hist_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  hist_entry_t   push_entry,
  input  logic          pop_req,
  output logic          pop,
  output logic [31:0]   stat_word,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] fill
);

  hist_entry_t mem [DEPTH];
  logic [31:0] last_word_q;
  logic        drop;
  logic        rd_adv;

  assign pop       = pop_req && en && (fill != '0);
  assign drop      = push && !pop && (fill == CW'(DEPTH));
  assign rd_adv    = pop || drop;
  assign stat_word = pop ? status_word(mem[rd_ptr]) : last_word_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      fill        <= '0;
      last_word_q <= '0;
    end else begin
      if (push)   wr_ptr <= PW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (rd_adv) rd_ptr <= PW'(wrap_inc(32'(rd_ptr), DEPTH));
      if (pop)    last_word_q <= stat_word;
      unique case ({push && !drop, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/lts_hist_regs.sv
module lts_hist_regs
  import lts_hist_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CTRL_OFS  = 'h310,
  parameter int MATCH_OFS = 'h320,
  parameter int N_MATCH   = 4,
  parameter int STAT_OFS  = 'h350
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       stat_word,
  output logic              cap_en,
  output logic              stat_rd,
  output logic [31:0]       rdata,
  output logic              rd_valid
);

  logic [15:0]           ctrl_q;
  logic [N_MATCH*16-1:0] match_flat;
  logic [31:0]           rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    ctrl_q <= '0;
    else if (wr_en && addr == ADDR_W'(CTRL_OFS))   ctrl_q <= wmask_merge(ctrl_q, wdata);
  end

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    logic [15:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                          q <= '0;
      else if (wr_en && addr == ADDR_W'(MATCH_OFS + 4*g))  q <= wmask_merge(q, wdata);
    end
    assign match_flat[g*16 +: 16] = q;
  end

  assign cap_en  = ctrl_q[0];
  assign stat_rd = rd_en && (addr == ADDR_W'(STAT_OFS));

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(CTRL_OFS)) rd_word = {16'h0, ctrl_q};
    if (addr == ADDR_W'(STAT_OFS)) rd_word = stat_word;
    for (int i = 0; i < N_MATCH; i++) begin
      if (addr == ADDR_W'(MATCH_OFS + 4*i)) rd_word = {16'h0, match_flat[i*16 +: 16]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/lts_history.sv
module lts_history
  import lts_hist_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ADDR_W    = 12,
  parameter int CTRL_OFS  = 'h310,
  parameter int MATCH_OFS = 'h320,
  parameter int N_MATCH   = 4,
  parameter int STAT_OFS  = 'h350,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        lnk_state_i,
  input  logic [2:0]        lnk_rate_i,
  input  logic [2:0]        lnk_sub_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o
);

  // Named internal events, observed by the bound checker.
  logic          cap_en;
  logic          push;
  logic          pop;
  logic          stat_rd;
  hist_entry_t   new_entry;
  logic [31:0]   stat_word;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] fill;

  lts_hist_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cap_en),
    .state_i (lnk_state_i),
    .rate_i  (lnk_rate_i),
    .sub_i   (lnk_sub_i),
    .push    (push),
    .entry   (new_entry)
  );

  lts_hist_ring #(.DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cap_en),
    .push       (push),
    .push_entry (new_entry),
    .pop_req    (stat_rd),
    .pop        (pop),
    .stat_word  (stat_word),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .fill       (fill)
  );

  lts_hist_regs #(
    .ADDR_W    (ADDR_W),
    .CTRL_OFS  (CTRL_OFS),
    .MATCH_OFS (MATCH_OFS),
    .N_MATCH   (N_MATCH),
    .STAT_OFS  (STAT_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr_i),
    .rd_en     (bus_rd_i),
    .addr      (bus_addr_i),
    .wdata     (bus_wdata_i),
    .stat_word (stat_word),
    .cap_en    (cap_en),
    .stat_rd   (stat_rd),
    .rdata     (bus_rdata_o),
    .rd_valid  (bus_rvalid_o)
  );

endmodule

// File: rtl/lts_hist_checker.sv
module lts_hist_checker #(
  parameter int DEPTH = 64,
  parameter int PW    = 6,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          cap_en,
  input logic          push,
  input logic          pop,
  input logic [5:0]    state_i,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [CW-1:0] fill
);

  // R10: read answered one cycle later
  a_r10_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R10: no valid without a read
  a_r10_no_idle_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9: pointers frozen while capture is off
  a_r9_frozen_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(wr_ptr) && $stable(rd_ptr)));

  // R8: store into a full ring drops the oldest entry
  a_r8_drop_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fill == CW'(DEPTH)) |=> (fill == CW'(DEPTH) && rd_ptr != $past(rd_ptr)));

  // R6: a lone pop shrinks the fill by one
  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (fill == $past(fill) - 1'b1));

  // R4: a held state stores nothing
  a_r4_held_state_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en) && $stable(state_i)) |-> !push);

endmodule

bind lts_history lts_hist_checker #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (bus_rd_i),
  .rd_valid (bus_rvalid_o),
  .cap_en   (cap_en),
  .push     (push),
  .pop      (pop),
  .state_i  (lnk_state_i),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr),
  .fill     (fill)
);

// File: tb/lts_history_tb.sv
module lts_history_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  st = '0;
  logic [2:0]  rt = '0;
  logic [2:0]  sb = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  always #2 clk = ~clk;  // 250 MHz

  lts_history u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .lnk_state_i  (st),
    .lnk_rate_i   (rt),
    .lnk_sub_i    (sb),
    .bus_wr_i     (wr),
    .bus_rd_i     (rd),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .bus_rvalid_o (rvalid)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [31:0] q[$];
  logic [5:0]  m_last;
  bit          m_have;
  logic [31:0] m_lastread;
  logic [15:0] m_ctrl;
  logic [15:0] m_match [4];
  logic        exp_valid;
  logic [31:0] exp_rdata;

  function automatic logic [15:0] merge(logic [15:0] cur, logic [31:0] d);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[b] = d[16+b] ? d[b] : cur[b];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_last = 0; m_have = 0; m_lastread = 0; m_ctrl = 0;
      for (int i = 0; i < 4; i++) m_match[i] = 0;
      exp_valid = 0; exp_rdata = 0;
    end else begin
      bit en;
      en = m_ctrl[0];
      exp_valid = rd;
      if (rd) begin
        if (addr == 12'h310) exp_rdata = {16'h0, m_ctrl};
        else if (addr == 12'h320) exp_rdata = {16'h0, m_match[0]};
        else if (addr == 12'h324) exp_rdata = {16'h0, m_match[1]};
        else if (addr == 12'h328) exp_rdata = {16'h0, m_match[2]};
        else if (addr == 12'h32C) exp_rdata = {16'h0, m_match[3]};
        else if (addr == 12'h350) begin
          if (en && q.size() > 0) m_lastread = q.pop_front();
          exp_rdata = m_lastread;
        end else exp_rdata = 0;
      end
      if (en && (!m_have || st != m_last)) begin
        if (q.size() == 64) void'(q.pop_front());
        q.push_back((32'(rt) << 20) | (32'(sb) << 8) | 32'(st));
        m_last = st; m_have = 1;
      end
      if (wr) begin
        if (addr == 12'h310) m_ctrl = merge(m_ctrl, wdata);
        if (addr == 12'h320) m_match[0] = merge(m_match[0], wdata);
        if (addr == 12'h324) m_match[1] = merge(m_match[1], wdata);
        if (addr == 12'h328) m_match[2] = merge(m_match[2], wdata);
        if (addr == 12'h32C) m_match[3] = merge(m_match[3], wdata);
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rvalid !== exp_valid) begin
        errors++;
        $display("FAIL R10 valid: actual %b expected %b", rvalid, exp_valid);
      end
      if (exp_valid) begin
        checks++;
        if (rdata !== exp_rdata) begin
          errors++;
          $display("FAIL %s rdata: actual %08h expected %08h", cur_req, rdata, exp_rdata);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
  endtask

  // Directed read with a literal expectation
  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s directed: actual %08h expected %08h", tag, rdata, e);
    end
  endtask

  task automatic step(input logic [5:0] s, input logic [2:0] r, input logic [2:0] u);
    @(negedge clk); st = s; rt = r; sb = u;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    expect_rd(12'h350, 32'h0, "R1");
    expect_rd(12'h310, 32'h0, "R1");

    cur_req = "R2";
    bus_wr(12'h320, 32'hFFFF0000);
    bus_wr(12'h324, 32'h00FF1234);
    expect_rd(12'h324, 32'h00000034, "R2");
    bus_wr(12'h328, 32'hFFFFABCD);
    bus_wr(12'h32C, 32'hFFFF0000);
    bus_rd(12'h328);
    expect_rd(12'h200, 32'h0, "R2");

    cur_req = "R3";
    step(6'd3, 3'd1, 3'd0);
    step(6'd5, 3'd1, 3'd0);
    expect_rd(12'h350, 32'h0, "R3");

    cur_req = "R5";
    step(6'h14, 3'd2, 3'd1);
    bus_wr(12'h310, 32'hFFFF0007);
    expect_rd(12'h310, 32'h7, "R3");
    expect_rd(12'h350, 32'h0020_0114, "R5");

    cur_req = "R4";
    step(6'h14, 3'd3, 3'd2);
    step(6'h14, 3'd0, 3'd0);
    step(6'h02, 3'd0, 3'd0);
    step(6'h02, 3'd1, 3'd0);
    step(6'h03, 3'd1, 3'd0);
    step(6'h14, 3'd1, 3'd2);
    step(6'h14, 3'd1, 3'd1);

    cur_req = "R6";
    repeat (3) bus_rd(12'h350);

    cur_req = "R7";
    expect_rd(12'h350, 32'h0010_0214, "R7");
    expect_rd(12'h350, 32'h0010_0214, "R7");
    step(6'h11, 3'd4, 3'd0);
    step(6'h12, 3'd4, 3'd0);
    expect_rd(12'h350, 32'h0040_0011, "R7");
    bus_rd(12'h350);
    bus_rd(12'h350);

    cur_req = "R8";
    for (int i = 0; i < 70; i++) step(6'((i * 7) % 61), 3'(i % 5), 3'(i % 3));
    for (int i = 0; i < 66; i++) bus_rd(12'h350);
    for (int i = 0; i < 64; i++) step(6'((i * 11) % 59 + 1), 3'(i % 4), 3'(i % 2));
    @(negedge clk); rd = 1; addr = 12'h350; st = 6'd62;
    @(negedge clk); rd = 0;
    for (int i = 0; i < 66; i++) bus_rd(12'h350);

    cur_req = "R9";
    step(6'd7, 3'd0, 3'd0);
    step(6'd8, 3'd0, 3'd0);
    bus_wr(12'h310, 32'hFFFF0000);
    step(6'd9, 3'd1, 3'd0);
    step(6'd10, 3'd1, 3'd0);
    bus_rd(12'h350);
    bus_rd(12'h350);
    bus_wr(12'h310, 32'h00010001);
    for (int i = 0; i < 5; i++) bus_rd(12'h350);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule